// File: doc/BRIEF.md
# Receive Frame Packer and Word Reader

This block sits between a receive byte stream and a CPU-facing data register. Each incoming Ethernet frame arrives as bytes on a valid/ready stream whose last byte is flagged. The block turns each frame into a packed record in a word-wide receive store. A record is a fixed marker word, then a header word carrying the stored length and a good-status code, then the frame bytes, then zero bytes up to the 60-byte minimum, then a freshly computed CRC-32, then zero bytes up to a word boundary. The block counts complete records and raises a receive interrupt flag for each one.

The CPU drains the store one 32-bit word per read strobe. The read side parses the header word of each record to find where that record ends, so the record count drops at the right word. A clear strobe on the count register empties the whole store. Back-pressure rule: `s_ready` is low between frames unless receive is enabled and enough space is free for a maximum-size record. Once the first byte of a frame is taken, `s_ready` stays high until the flagged last byte, so a frame is never stalled partway. If the store proves too small for the frame, the bytes are still consumed but the partial record is discarded.

Top module: `rx_frame_packer`

## Requirements
- R1: Between frames, `s_ready` is high only when `rx_en` is 1 and the free space is at least MAX_FRAME+10 bytes. Free space is FIFO_BYTES minus 4 times the number of stored words. Space released by reads raises `s_ready` again. Once a frame has started, `s_ready` is held high through its last byte.
- R2: A frame of L bytes with L below 60 is stored with zero bytes appended up to 60 bytes. The low 16 bits of the header word hold max(L,60)+4.
- R3: Record word 0 is MAGIC. Word 1 is {16'h0001, max(L,60)+4}. Bytes are packed little-endian, with the earliest byte in bits 7:0. After the data and padding comes the CRC-32 of data plus padding, least significant byte first. This CRC uses reflected polynomial 0xEDB88320, starts at all ones and is complemented at the end. Zero bytes then fill to a word boundary.
- R4: When a record is complete, `pkt_count` rises by one and `irq` goes to 1. `irq` stays at 1 until an `irq_clr` pulse.
- R5: Each `rd_pop` while `pkt_count` is nonzero returns the next stored word on `rd_data` and consumes it. A record is 2 + ceil((max(L,60)+4)/4) words long. When its last word is consumed, `pkt_count` drops by one.
- R6: While `pkt_count` is 0, `rd_data` is 0 and `rd_pop` consumes nothing. The next record is still read from its MAGIC word.
- R7: A `cnt_flush` pulse empties the store, sets `pkt_count` to 0 and restarts parsing, so the next record is read from its MAGIC word.
- R8: A frame of L bytes that begins while F bytes are free is dropped if L+15 > F. Its bytes are consumed, `pkt_count` does not change, `irq` is not set and nothing becomes readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted when high with `s_valid` |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the last byte of a frame |
| rd_pop | input | 1 | Data register read strobe, one word per cycle |
| rd_data | output | 32 | Word returned by the current read |
| cnt_flush | input | 1 | Clear strobe on the count register |
| pkt_count | output | $clog2(FIFO_BYTES/4)+1 | Number of complete records stored |
| irq_clr | input | 1 | Clears the receive interrupt flag |
| irq | output | 1 | Receive interrupt flag |

## Verification
The bench builds the block with FIFO_BYTES=256 and MAX_FRAME=100, so the acceptance threshold is 110 bytes. At that size, three minimum-size records are enough to push free space below the threshold, and one read of a record brings it back above. A 241-byte frame fills the store to exactly its last word and wraps the pointers. A 242-byte frame crosses the drop rule by one byte. Frame lengths on both sides of 60 and of word alignment exercise the padding, CRC byte lanes and fill.

// File: rtl/rx_pack_pkg.sv
package rx_pack_pkg;

  localparam int MIN_PAYLOAD = 60;
  localparam logic [15:0] RX_STATUS_OK = 16'h0001;

  typedef enum logic [2:0] {
    PK_IDLE, PK_DATA, PK_PAD, PK_CRC, PK_FILL, PK_HDR, PK_DROP
  } pk_state_e;

  typedef enum logic [1:0] {
    RP_MAGIC, RP_HDR, RP_BODY
  } rp_pos_e;

  function automatic logic [31:0] crc32_step(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in ^ {24'h0, b};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/rx_word_store.sv
module rx_word_store #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/rx_packer.sv
module rx_packer
  import rx_pack_pkg::*;
#(
  parameter int          AW        = 10,
  parameter int          MAX_FRAME = 1522,
  parameter logic [31:0] MAGIC     = 32'h0143414D,
  localparam int         FREE_W    = AW + 3,
  localparam int         THRESH    = MAX_FRAME + 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              flush,
  input  logic [FREE_W-1:0] free_bytes,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [31:0]       mem_wdata,
  output logic              commit,
  output logic [AW:0]       commit_words
);

  pk_state_e   state;
  logic [AW-1:0] wptr, cptr;
  logic [1:0]  lane, kidx;
  logic [31:0] acc, crc;
  logic [15:0] nbytes;

  logic        take, over, emit, word_done;
  logic [7:0]  emit_byte;
  logic [15:0] n_inc, wtmp;
  logic [31:0] acc_next, crc_out;

  assign take    = s_valid && s_ready;
  assign n_inc   = nbytes + 16'd1;
  assign over    = (32'(n_inc) + 32'd15) > 32'(free_bytes);
  assign crc_out = ~crc;

  always_comb begin
    unique case (state)
      PK_IDLE:          s_ready = rx_en && !flush && (32'(free_bytes) >= THRESH);
      PK_DATA, PK_DROP: s_ready = 1'b1;
      default:          s_ready = 1'b0;
    endcase
  end

  always_comb begin
    emit      = 1'b0;
    emit_byte = 8'h00;
    unique case (state)
      PK_IDLE: begin emit = take;          emit_byte = s_data; end
      PK_DATA: begin emit = take && !over; emit_byte = s_data; end
      PK_PAD:  emit = 1'b1;
      PK_CRC:  begin emit = 1'b1; emit_byte = crc_out[{kidx, 3'b000} +: 8]; end
      PK_FILL: emit = 1'b1;
      default: ;
    endcase
  end

  assign acc_next  = (lane == 2'd0) ? {24'h0, emit_byte}
                                    : (acc | (32'(emit_byte) << {lane, 3'b000}));
  assign word_done = emit && (lane == 2'd3);

  always_comb begin
    if (state == PK_HDR) begin
      mem_we    = !flush;
      mem_waddr = cptr + AW'(1);
      mem_wdata = {RX_STATUS_OK, nbytes + 16'd4};
    end else if (state == PK_IDLE && take) begin
      mem_we    = 1'b1;
      mem_waddr = cptr;
      mem_wdata = MAGIC;
    end else begin
      mem_we    = word_done;
      mem_waddr = wptr;
      mem_wdata = acc_next;
    end
  end

  assign wtmp         = 16'd2 + ((nbytes + 16'd7) >> 2);
  assign commit       = (state == PK_HDR) && !flush;
  assign commit_words = wtmp[AW:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PK_IDLE;
      wptr   <= '0;
      cptr   <= '0;
      lane   <= '0;
      kidx   <= '0;
      acc    <= '0;
      crc    <= '0;
      nbytes <= '0;
    end else if (flush) begin
      wptr  <= '0;
      cptr  <= '0;
      lane  <= '0;
      state <= ((state == PK_DATA || state == PK_DROP) && !(take && s_last)) ? PK_DROP : PK_IDLE;
    end else begin
      if (emit) begin
        acc  <= acc_next;
        lane <= lane + 2'd1;
        if (lane == 2'd3) wptr <= wptr + AW'(1);
      end
      unique case (state)
        PK_IDLE: if (take) begin
          wptr   <= cptr + AW'(2);
          crc    <= crc32_step(32'hFFFF_FFFF, s_data);
          nbytes <= 16'd1;
          state  <= s_last ? PK_PAD : PK_DATA;
        end
        PK_DATA: if (take) begin
          if (over) begin
            wptr  <= cptr;
            lane  <= '0;
            state <= s_last ? PK_IDLE : PK_DROP;
          end else begin
            nbytes <= n_inc;
            crc    <= crc32_step(crc, s_data);
            kidx   <= '0;
            if (s_last) state <= (n_inc < 16'(MIN_PAYLOAD)) ? PK_PAD : PK_CRC;
          end
        end
        PK_PAD: begin
          nbytes <= n_inc;
          crc    <= crc32_step(crc, 8'h00);
          kidx   <= '0;
          if (n_inc == 16'(MIN_PAYLOAD)) state <= PK_CRC;
        end
        PK_CRC: begin
          kidx <= kidx + 2'd1;
          if (kidx == 2'd3) state <= (lane == 2'd3) ? PK_HDR : PK_FILL;
        end
        PK_FILL: if (lane == 2'd3) state <= PK_HDR;
        PK_HDR: begin
          cptr  <= wptr;
          state <= PK_IDLE;
        end
        PK_DROP: if (take && s_last) begin
          wptr  <= cptr;
          lane  <= '0;
          state <= PK_IDLE;
        end
        default: state <= PK_IDLE;
      endcase
    end
  end

  AST_PAD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PK_HDR) |-> (nbytes >= 16'(MIN_PAYLOAD))); // R2

  AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PK_HDR) |-> (lane == 2'd0)); // R3

  AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PK_DATA) |-> s_ready); // R1

endmodule

// File: rtl/rx_reader.sv
module rx_reader
  import rx_pack_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          pop,
  input  logic          have_pkt,
  input  logic [31:0]   mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [31:0]   rd_data,
  output logic          pop_word,
  output logic          rec_done
);

  rp_pos_e     pos;
  logic [15:0] remain;
  logic [AW-1:0] rptr;

  assign raddr    = rptr;
  assign rd_data  = have_pkt ? mem_rdata : 32'h0;
  assign pop_word = pop && have_pkt && !flush;
  assign rec_done = pop_word && (pos == RP_BODY) && (remain == 16'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr   <= '0;
      pos    <= RP_MAGIC;
      remain <= '0;
    end else if (flush) begin
      rptr   <= '0;
      pos    <= RP_MAGIC;
      remain <= '0;
    end else if (pop_word) begin
      rptr <= rptr + AW'(1);
      unique case (pos)
        RP_MAGIC: pos <= RP_HDR;
        RP_HDR: begin
          remain <= (mem_rdata[15:0] + 16'd3) & ~16'd3;
          pos    <= RP_BODY;
        end
        default: begin
          remain <= remain - 16'd4;
          if (remain == 16'd4) pos <= RP_MAGIC;
        end
      endcase
    end
  end

  AST_EMPTY_POP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !have_pkt && !flush) |=> $stable(rptr)); // R6

  AST_BODY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == RP_BODY) |-> (remain != 16'd0)); // R5

endmodule

// File: rtl/rx_frame_packer.sv
module rx_frame_packer
  import rx_pack_pkg::*;
#(
  parameter int          FIFO_BYTES = 4096,
  parameter int          MAX_FRAME  = 1522,
  parameter logic [31:0] MAGIC      = 32'h0143414D,
  localparam int         DEPTH      = FIFO_BYTES / 4,
  localparam int         AW         = $clog2(DEPTH),
  localparam int         FREE_W     = AW + 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [7:0]  s_data,
  input  logic        s_last,
  input  logic        rd_pop,
  output logic [31:0] rd_data,
  input  logic        cnt_flush,
  output logic [AW:0] pkt_count,
  input  logic        irq_clr,
  output logic        irq
);

  logic [AW:0]       used_words;
  logic [FREE_W-1:0] free_bytes;
  logic              mem_we, commit, pop_word, rec_done;
  logic [AW-1:0]     mem_waddr, raddr;
  logic [31:0]       mem_wdata, mem_rdata;
  logic [AW:0]       commit_words;

  assign free_bytes = FREE_W'(FIFO_BYTES) - {used_words, 2'b00};

  rx_packer #(.AW(AW), .MAX_FRAME(MAX_FRAME), .MAGIC(MAGIC)) u_packer (
    .clk, .rst_n, .rx_en, .flush(cnt_flush), .free_bytes,
    .s_valid, .s_ready, .s_data, .s_last,
    .mem_we, .mem_waddr, .mem_wdata, .commit, .commit_words
  );

  rx_word_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk, .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr, .rdata(mem_rdata)
  );

  rx_reader #(.AW(AW)) u_reader (
    .clk, .rst_n, .flush(cnt_flush), .pop(rd_pop), .have_pkt(pkt_count != '0),
    .mem_rdata, .raddr, .rd_data, .pop_word, .rec_done
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_words <= '0;
      pkt_count  <= '0;
      irq        <= 1'b0;
    end else begin
      if (cnt_flush) begin
        used_words <= '0;
        pkt_count  <= '0;
      end else begin
        used_words <= used_words + (commit ? commit_words : '0)
                      - {{AW{1'b0}}, pop_word};
        pkt_count  <= pkt_count + {{AW{1'b0}}, commit} - {{AW{1'b0}}, rec_done};
      end
      if (commit)       irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    used_words <= (AW+1)'(DEPTH)); // R8

  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !rec_done && !cnt_flush) |=> (pkt_count == $past(pkt_count) + {{AW{1'b0}}, 1'b1})); // R4

  AST_IRQ_ON_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> irq); // R4

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_flush |=> (pkt_count == '0 && used_words == '0)); // R7

endmodule

// File: tb/rx_frame_packer_tb.sv
`timescale 1ns/1ps
module rx_frame_packer_tb;

  localparam int          FB    = 256;
  localparam int          MF    = 100;
  localparam logic [31:0] MAGIC = 32'h0143414D;
  localparam int          CW    = $clog2(FB/4) + 1;

  typedef struct packed { int len; int seed; int words; int hdr; } vec_t;
  localparam vec_t VT [6] = '{
    '{1,   8'h11, 18, 64},
    '{59,  8'h22, 18, 64},
    '{60,  8'h33, 18, 64},
    '{61,  8'h44, 19, 65},
    '{63,  8'h55, 19, 67},
    '{100, 8'h66, 28, 104}
  };

  logic clk = 0, rst_n = 0;
  logic rx_en = 0, s_valid = 0, s_last = 0, rd_pop = 0, cnt_flush = 0, irq_clr = 0;
  logic [7:0] s_data = 0;
  logic s_ready, irq;
  logic [31:0] rd_data;
  logic [CW-1:0] pkt_count;

  always #2.5 clk = ~clk;

  rx_frame_packer #(.FIFO_BYTES(FB), .MAX_FRAME(MF), .MAGIC(MAGIC)) u_dut (
    .clk, .rst_n, .rx_en, .s_valid, .s_ready, .s_data, .s_last,
    .rd_pop, .rd_data, .cnt_flush, .pkt_count, .irq_clr, .irq
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0]  fbuf [0:299];
  logic [7:0]  rb   [0:319];
  logic [31:0] ew   [0:79];
  int ewn;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic build(input int len, input int seed);
    int p, idx;
    logic [31:0] c, hdr;
    p = (len < 60) ? 60 : len;
    for (int i = 0; i < len; i++) fbuf[i] = 8'(seed + i * 7);
    hdr = {16'h0001, 16'(p + 4)};
    for (int b = 0; b < 4; b++) begin
      rb[b]     = MAGIC[8*b +: 8];
      rb[4 + b] = hdr[8*b +: 8];
    end
    for (int i = 0; i < p; i++) rb[8 + i] = (i < len) ? fbuf[i] : 8'h00;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < p; i++) begin
      c = c ^ {24'h0, rb[8 + i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    c = ~c;
    idx = 8 + p;
    for (int b = 0; b < 4; b++) rb[idx + b] = c[8*b +: 8];
    idx = idx + 4;
    while (idx % 4 != 0) begin rb[idx] = 8'h00; idx++; end
    ewn = idx / 4;
    for (int w = 0; w < ewn; w++) ew[w] = {rb[4*w+3], rb[4*w+2], rb[4*w+1], rb[4*w]};
  endtask

  task automatic send(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_valid = 1; s_data = fbuf[i]; s_last = (i == len - 1);
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    s_valid = 0; s_last = 0;
    repeat (80) @(negedge clk);
  endtask

  task automatic read_rec(input string req, input int nw);
    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      rd_pop = 1;
      #1;
      chk(req, rd_data, ew[w]);
    end
    @(negedge clk);
    rd_pop = 0;
    #1;
  endtask

  task automatic pulse_flush();
    @(negedge clk); cnt_flush = 1;
    @(negedge clk); cnt_flush = 0; #1;
  endtask

  task automatic pulse_irq_clr();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0; #1;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R4 reset count", 32'(pkt_count), 32'h0);
    chk("R4 reset irq", 32'(irq), 32'h0);
    chk("R1 ready low while disabled", 32'(s_ready), 32'h0);
    chk("R6 empty read returns zero", rd_data, 32'h0);

    rx_en = 1;
    @(negedge clk); #1;
    chk("R1 ready when enabled and empty", 32'(s_ready), 32'h1);

    // Vector table: frame lengths around the pad limit and word alignment
    for (int v = 0; v < 6; v++) begin
      build(VT[v].len, VT[v].seed);
      send(VT[v].len);
      chk("R4 count after record", 32'(pkt_count), 32'h1);
      chk("R4 irq after record", 32'(irq), 32'h1);
      chk("R2 header length", {16'h0, ew[1][15:0]}, 32'(VT[v].hdr));
      read_rec("R3 record word", VT[v].words);
      chk("R5 count after last word", 32'(pkt_count), 32'h0);
      pulse_irq_clr();
      chk("R4 irq cleared", 32'(irq), 32'h0);
    end

    // Back-pressure: three minimum records leave 40 bytes free
    pulse_flush();
    build(60, 8'h77);
    send(60);
    send(60);
    chk("R1 ready with 112 bytes free", 32'(s_ready), 32'h1);
    send(60);
    chk("R1 count three", 32'(pkt_count), 32'h3);
    chk("R1 ready low with 40 bytes free", 32'(s_ready), 32'h0);
    read_rec("R5 word under back-pressure", 18);
    chk("R5 count after one read", 32'(pkt_count), 32'h2);
    chk("R1 ready restored by read", 32'(s_ready), 32'h1);

    // Flush and empty reads
    pulse_flush();
    chk("R7 count after flush", 32'(pkt_count), 32'h0);
    @(negedge clk); rd_pop = 1; #1;
    chk("R6 pop on empty returns zero", rd_data, 32'h0);
    @(negedge clk); rd_pop = 0; #1;
    build(61, 8'h19);
    send(61);
    chk("R7 count after post-flush frame", 32'(pkt_count), 32'h1);
    read_rec("R7 R6 record from magic", 19);
    chk("R5 count drained", 32'(pkt_count), 32'h0);
    pulse_irq_clr();

    // Drop boundary: 242+15 > 256 dropped, 241+15 = 256 kept
    pulse_flush();
    build(242, 8'h5A);
    send(242);
    chk("R8 dropped frame count", 32'(pkt_count), 32'h0);
    chk("R8 dropped frame irq", 32'(irq), 32'h0);
    chk("R8 dropped frame not readable", rd_data, 32'h0);
    build(241, 8'hA5);
    send(241);
    chk("R8 fitting frame count", 32'(pkt_count), 32'h1);
    chk("R1 ready low when full", 32'(s_ready), 32'h0);
    read_rec("R3 full-store record word", 64);
    chk("R5 count after full record", 32'(pkt_count), 32'h0);
    chk("R1 ready after drain", 32'(s_ready), 32'h1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule